// File: doc/BRIEF.md
# I2C Bit-Level Master Engine with Late-Acknowledge Recovery

This block is the bit-level master side of an I2C link. It drives the clock line and a
tri-state data line from a fast system clock. It runs one primitive at a time: start
condition, stop condition, write byte, read byte, drive acknowledge, or sample
acknowledge. A command is taken in when the engine is idle. A one-cycle completion pulse
marks its end. All bus timing is built from one parameter, `HALF_CYCLES`: the number of
system clocks in each timing segment.

The acknowledge sample handles a slave that has lost its place in a byte. If the data
line is high on the first acknowledge clock, the engine keeps clocking and searches for
the line to go low. If it finds that low, it reads out a full byte, acknowledges it and
closes with a stop, which puts the slave back into a known state. The result is reported
as late. If the line never goes low, the result is fatal. A controller above this engine
builds full transfers and retry policy out of these primitives.

The data line appears as three signals: an enable, a driven level and the sensed level.
The pad wrapper turns these into an open-drain pin.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe` is 0, `sda_o` is 0, `cmd_ready` is 1, `cmd_done` is 0, `ack_status` is 0 (OK) and `rx_byte` is 0.
- R2: The engine accepts a command only when `cmd_ready` is 1, `cmd_valid` is 1 and `cmd_code` is 0 to 5. While a command runs, `cmd_ready` is 0 and `cmd_valid` is ignored. Codes 6 and 7 are ignored and change no output.
- R3: Every timing segment lasts exactly `HALF_CYCLES` clocks. Each bit slot is three segments: clock low, clock high, clock low. The data enable and level stay constant for the whole slot. The data line is sampled on the last cycle of the high segment.
- R4: Code 0 (start) drives three segments, given as (scl, data): (1, driven 1), then (1, driven 0), then (0, driven 0).
- R5: Code 1 (stop) drives three segments: (0, driven 0), then (1, driven 0), then (1, released).
- R6: Code 2 (write) sends `cmd_wdata` as 8 bit slots, most significant bit first, with `sda_oe` at 1.
- R7: Code 3 (read) runs 8 bit slots with the data line released. It assembles the sampled bits most significant first and loads the result into `rx_byte` when `cmd_done` rises.
- R8: Code 4 (send acknowledge) is one bit slot with the data line driven 0.
- R9: Code 5 (sample acknowledge) runs one released bit slot. If the sample is 0, it completes after that slot with `ack_status` 0 (OK).
- R10: If the first acknowledge sample is 1, up to 7 more released slots follow. When one of them samples 0, the engine reads 8 more released slots into `rx_byte`, sends one driven-0 slot and runs the R5 stop sequence. It then completes with `ack_status` 1 (late).
- R11: If all 8 acknowledge samples are 1, the engine completes right after the eighth slot with `ack_status` 2 (fatal). It sends no stop.
- R12: `ack_status` changes only in a cycle where `cmd_done` is 1 following code 5. Other commands leave it unchanged.
- R13: `cmd_done` is high for exactly one cycle, with `cmd_ready` already 1. Between commands, the bus outputs hold the levels of the last segment driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | Command code (0 start, 1 stop, 2 write, 3 read, 4 send ack, 5 sample ack) |
| cmd_wdata | input | DATA_BITS | Byte to send for code 2 |
| cmd_ready | output | 1 | Engine idle, a command can be accepted |
| cmd_done | output | 1 | One-cycle completion pulse |
| rx_byte | output | DATA_BITS | Last byte read (read or recovery drain) |
| ack_status | output | 2 | Result of the last acknowledge sample: 0 OK, 1 late, 2 fatal |
| scl_o | output | 1 | Bus clock level |
| sda_oe | output | 1 | Data line drive enable |
| sda_o | output | 1 | Data line level when driven |
| sda_i | input | 1 | Sensed data line level |

## Verification
Assertions check, on every cycle:
- that the data line holds still while the clock is high inside bit slots;
- that the data line is released during every receive slot;
- that the segment counter stays in range;
- that the completion pulse lasts one cycle;
- that the acknowledge status changes only together with completion.

The start and stop shapes, the bit order and the length of every segment can only be shown by the bench, as can the three acknowledge outcomes. The bench shows these by comparing the bus against a cycle-by-cycle expected waveform while it plays a slave that acknowledges at chosen positions. The byte drained in the recovery path, and the points where ACK search gives up, likewise need those scripted scenarios.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [1:0] {
    ACK_OK    = 2'd0,
    ACK_LATE  = 2'd1,
    ACK_FATAL = 2'd2
  } ack_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START,
    PH_STOP,
    PH_TX,
    PH_RX,
    PH_ACK_OUT,
    PH_HUNT,
    PH_DRAIN,
    PH_DRAIN_ACK
  } phase_e;

  localparam logic [2:0] CODE_START   = 3'd0;
  localparam logic [2:0] CODE_STOP    = 3'd1;
  localparam logic [2:0] CODE_WRITE   = 3'd2;
  localparam logic [2:0] CODE_READ    = 3'd3;
  localparam logic [2:0] CODE_ACK_OUT = 3'd4;
  localparam logic [2:0] CODE_ACK_IN  = 3'd5;

  localparam logic [1:0] SEG_LAST = 2'd2;

  function automatic logic code_legal(input logic [2:0] c);
    return c <= CODE_ACK_IN;
  endfunction

  // clock level inside a bit slot: high only in the middle segment
  function automatic logic slot_scl(input logic [1:0] seg);
    return seg == 2'd1;
  endfunction

  function automatic logic start_scl(input logic [1:0] seg);
    return seg != 2'd2;
  endfunction

  function automatic logic start_sda(input logic [1:0] seg);
    return seg == 2'd0;
  endfunction

  function automatic logic stop_scl(input logic [1:0] seg);
    return seg != 2'd0;
  endfunction

  function automatic logic stop_drive(input logic [1:0] seg);
    return seg != 2'd2;
  endfunction

  function automatic logic phase_receives(input phase_e p);
    return (p == PH_RX) || (p == PH_HUNT) || (p == PH_DRAIN);
  endfunction

  function automatic logic phase_is_slot(input phase_e p);
    return (p == PH_TX) || (p == PH_RX) || (p == PH_ACK_OUT) ||
           (p == PH_HUNT) || (p == PH_DRAIN) || (p == PH_DRAIN_ACK);
  endfunction

endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int HALF_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic seg_end
);
  localparam int CW = $clog2(HALF_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign seg_end = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || seg_end)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  a_r3_cleared_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/i2c_shift_unit.sv
module i2c_shift_unit #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] load_byte,
  input  logic                 tx_adv,
  input  logic                 rx_take,
  input  logic                 rx_bit,
  output logic                 tx_msb,
  output logic [DATA_BITS-1:0] rx_word
);
  logic [DATA_BITS-1:0] tx_sr;

  assign tx_msb = tx_sr[DATA_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_sr <= '0;
    else if (load)   tx_sr <= load_byte;
    else if (tx_adv) tx_sr <= {tx_sr[DATA_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_word <= '0;
    else if (rx_take) rx_word <= {rx_word[DATA_BITS-2:0], rx_bit};
  end

  a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tx_msb == $past(load_byte[DATA_BITS-1])));

  a_r7_sample_enters_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> (rx_word[0] == $past(rx_bit)));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int HALF_CYCLES = 250,
  parameter int DATA_BITS   = 8,
  parameter int ACK_TRIES   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_code,
  input  logic [DATA_BITS-1:0] cmd_wdata,
  output logic                 cmd_ready,
  output logic                 cmd_done,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic [1:0]           ack_status,
  output logic                 scl_o,
  output logic                 sda_oe,
  output logic                 sda_o,
  input  logic                 sda_i
);
  localparam int MAXB  = (DATA_BITS > ACK_TRIES) ? DATA_BITS : ACK_TRIES;
  localparam int BIT_W = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam logic [BIT_W-1:0] LAST_DATA_BIT = BIT_W'(DATA_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_TRY      = BIT_W'(ACK_TRIES - 1);

  phase_e               phase;
  logic [1:0]           seg;
  logic [BIT_W-1:0]     bit_idx;
  logic                 recover;
  logic                 samp;
  logic                 done_q;
  ack_e                 status_q;
  logic [DATA_BITS-1:0] rx_byte_q;
  logic                 scl_h, oe_h, out_h;
  logic                 scl_c, oe_c, out_c;

  // named internal events
  logic                 active;
  logic                 accept;
  logic                 seg_end;
  logic                 slot_end;
  logic                 sample_now;
  logic                 last_data_bit;
  logic                 tx_msb;
  logic                 tx_adv;
  logic                 rx_take;
  logic [DATA_BITS-1:0] rx_word;

  assign active        = (phase != PH_IDLE);
  assign accept        = !active && cmd_valid && code_legal(cmd_code);
  assign slot_end      = seg_end && (seg == SEG_LAST);
  assign sample_now    = seg_end && (seg == 2'd1) && phase_receives(phase);
  assign last_data_bit = (bit_idx == LAST_DATA_BIT);
  assign tx_adv        = slot_end && (phase == PH_TX) && !last_data_bit;
  assign rx_take       = sample_now && ((phase == PH_RX) || (phase == PH_DRAIN));

  i2c_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .seg_end (seg_end)
  );

  i2c_shift_unit #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_byte (cmd_wdata),
    .tx_adv    (tx_adv),
    .rx_take   (rx_take),
    .rx_bit    (sda_i),
    .tx_msb    (tx_msb),
    .rx_word   (rx_word)
  );

  // bus levels decoded from the current phase and segment
  always_comb begin
    scl_c = scl_h;
    oe_c  = oe_h;
    out_c = out_h;
    unique case (phase)
      PH_START: begin
        scl_c = start_scl(seg);
        oe_c  = 1'b1;
        out_c = start_sda(seg);
      end
      PH_STOP: begin
        scl_c = stop_scl(seg);
        oe_c  = stop_drive(seg);
        out_c = 1'b0;
      end
      PH_TX: begin
        scl_c = slot_scl(seg);
        oe_c  = 1'b1;
        out_c = tx_msb;
      end
      PH_ACK_OUT, PH_DRAIN_ACK: begin
        scl_c = slot_scl(seg);
        oe_c  = 1'b1;
        out_c = 1'b0;
      end
      PH_RX, PH_HUNT, PH_DRAIN: begin
        scl_c = slot_scl(seg);
        oe_c  = 1'b0;
        out_c = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_h <= 1'b1;
      oe_h  <= 1'b0;
      out_h <= 1'b0;
    end else if (active) begin
      scl_h <= scl_c;
      oe_h  <= oe_c;
      out_h <= out_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          samp <= 1'b1;
    else if (sample_now) samp <= sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      seg       <= 2'd0;
      bit_idx   <= '0;
      recover   <= 1'b0;
      done_q    <= 1'b0;
      status_q  <= ACK_OK;
      rx_byte_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        seg     <= 2'd0;
        bit_idx <= '0;
        recover <= 1'b0;
        unique case (cmd_code)
          CODE_START:   phase <= PH_START;
          CODE_STOP:    phase <= PH_STOP;
          CODE_WRITE:   phase <= PH_TX;
          CODE_READ:    phase <= PH_RX;
          CODE_ACK_OUT: phase <= PH_ACK_OUT;
          default:      phase <= PH_HUNT;
        endcase
      end else if (seg_end) begin
        if (seg != SEG_LAST) begin
          seg <= seg + 2'd1;
        end else begin
          seg <= 2'd0;
          unique case (phase)
            PH_START, PH_ACK_OUT: begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end
            PH_STOP: begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
              if (recover) status_q <= ACK_LATE;
            end
            PH_TX: begin
              if (last_data_bit) begin
                phase  <= PH_IDLE;
                done_q <= 1'b1;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
            PH_RX: begin
              if (last_data_bit) begin
                phase     <= PH_IDLE;
                done_q    <= 1'b1;
                rx_byte_q <= rx_word;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
            PH_HUNT: begin
              if (!samp) begin
                if (bit_idx == '0) begin
                  phase    <= PH_IDLE;
                  done_q   <= 1'b1;
                  status_q <= ACK_OK;
                end else begin
                  phase   <= PH_DRAIN;
                  bit_idx <= '0;
                end
              end else if (bit_idx == LAST_TRY) begin
                phase    <= PH_IDLE;
                done_q   <= 1'b1;
                status_q <= ACK_FATAL;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
            PH_DRAIN: begin
              if (last_data_bit) begin
                phase     <= PH_DRAIN_ACK;
                rx_byte_q <= rx_word;
                bit_idx   <= '0;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
            PH_DRAIN_ACK: begin
              phase   <= PH_STOP;
              recover <= 1'b1;
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign cmd_ready  = !active;
  assign cmd_done   = done_q;
  assign rx_byte    = rx_byte_q;
  assign ack_status = status_q;
  assign scl_o      = scl_c;
  assign sda_oe     = oe_c;
  assign sda_o      = out_c;

  a_r13_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  a_r13_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> cmd_ready);

  a_r3_data_still_while_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_is_slot(phase) && scl_o && $past(scl_o)) |-> ($stable(sda_o) && $stable(sda_oe)));

  a_r7_released_on_receive: assert property (@(posedge clk) disable iff (!rst_n)
    phase_receives(phase) |-> !sda_oe);

  a_r12_status_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_status) |-> cmd_done);

  a_r2_illegal_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && !code_legal(cmd_code)) |=> cmd_ready);

  a_r4_start_falls_under_high_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_START) && $fell(sda_o)) |-> scl_o);

endmodule

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       sda_i = 1'b1;
  logic       cmd_ready, cmd_done, scl_o, sda_oe, sda_o;
  logic [7:0] rx_byte;
  logic [1:0] ack_status;

  always #10 clk = ~clk;

  i2c_byte_engine #(.HALF_CYCLES(H), .DATA_BITS(8), .ACK_TRIES(8)) i_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
    .rx_byte(rx_byte), .ack_status(ack_status), .scl_o(scl_o), .sda_oe(sda_oe),
    .sda_o(sda_o), .sda_i(sda_i)
  );

  int checks = 0;
  int fails  = 0;

  // expected bus: {scl, oe, out, ready, done} plus the line level the slave shows
  logic [4:0] exp_q[$];
  logic       sin_q[$];
  logic       m_scl = 1'b1, m_oe = 1'b0, m_out = 1'b0;
  logic [1:0] m_status = 2'd0;
  logic [7:0] m_rx = 8'h00;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic seg(input logic s, input logic o, input logic d, input logic sin);
    for (int i = 0; i < H; i++) begin
      exp_q.push_back({s, o, d, 1'b0, 1'b0});
      sin_q.push_back(sin);
    end
    m_scl = s; m_oe = o; m_out = d;
  endtask

  task automatic slot(input logic o, input logic d, input logic sin);
    seg(1'b0, o, d, sin);
    seg(1'b1, o, d, sin);
    seg(1'b0, o, d, sin);
  endtask

  task automatic stop_shape();
    seg(1'b0, 1'b1, 1'b0, 1'b1);
    seg(1'b1, 1'b1, 1'b0, 1'b1);
    seg(1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  // play the queued waveform after issuing a command; optional stray request mid-way
  task automatic play(input string req, input logic [2:0] code, input logic [7:0] wd,
                      input bit stray);
    exp_q.push_back({m_scl, m_oe, m_out, 1'b1, 1'b1});
    sin_q.push_back(1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_wdata = wd;
    for (int k = 0; exp_q.size() > 0; k++) begin
      logic [4:0] e;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (stray && k == 5) begin
        cmd_valid = 1'b1; cmd_code = 3'd3; cmd_wdata = 8'hFF;
      end
      e = exp_q.pop_front();
      sda_i = sin_q.pop_front();
      check(req, {27'd0, scl_o, sda_oe, sda_o, cmd_ready, cmd_done}, {27'd0, e});
    end
    cmd_valid = 1'b0;
    sda_i = 1'b1;
    check("R12 status", {30'd0, ack_status}, {30'd0, m_status});
    check("R7 rx_byte", {24'd0, rx_byte}, {24'd0, m_rx});
  endtask

  task automatic do_start();
    seg(1'b1, 1'b1, 1'b1, 1'b1);
    seg(1'b1, 1'b1, 1'b0, 1'b1);
    seg(1'b0, 1'b1, 1'b0, 1'b1);
    play("R4 start", 3'd0, 8'h00, 1'b0);
  endtask

  task automatic do_stop();
    stop_shape();
    play("R5 stop", 3'd1, 8'h00, 1'b0);
  endtask

  task automatic do_write(input logic [7:0] v, input bit stray);
    for (int i = 7; i >= 0; i--) slot(1'b1, v[i], 1'b1);
    play(stray ? "R2 busy ignores request / R6 write" : "R6 write", 3'd2, v, stray);
  endtask

  task automatic do_read(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) slot(1'b0, 1'b0, v[i]);
    m_rx = v;
    play("R7 read", 3'd3, 8'h00, 1'b0);
  endtask

  task automatic do_ack_out();
    slot(1'b1, 1'b0, 1'b1);
    play("R8 send ack", 3'd4, 8'h00, 1'b0);
  endtask

  // pos: slot index where the slave pulls low (0 on time, 1..7 late, 8 never)
  task automatic do_ack_in(input int pos, input logic [7:0] drain);
    string req;
    for (int i = 0; i < 8; i++) begin
      slot(1'b0, 1'b0, (i == pos) ? 1'b0 : 1'b1);
      if (i == pos) break;
    end
    if (pos == 0) begin
      m_status = 2'd0; req = "R9 ack on time";
    end else if (pos >= 8) begin
      m_status = 2'd2; req = "R11 ack fatal";
    end else begin
      for (int i = 7; i >= 0; i--) slot(1'b0, 1'b0, drain[i]);
      slot(1'b1, 1'b0, 1'b1);
      stop_shape();
      m_rx = drain;
      m_status = 2'd1; req = "R10 late ack recovery";
    end
    play(req, 3'd5, 8'h00, 1'b0);
  endtask

  task automatic ignored_code(input logic [2:0] code);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check("R2 illegal code ignored",
            {27'd0, scl_o, sda_oe, sda_o, cmd_ready, cmd_done},
            {27'd0, m_scl, m_oe, m_out, 1'b1, 1'b0});
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset bus", {29'd0, scl_o, sda_oe, sda_o}, {29'd0, 3'b100});
    check("R1 reset handshake", {30'd0, cmd_ready, cmd_done}, {30'd0, 2'b10});
    check("R1 reset status", {30'd0, ack_status}, 32'd0);
    check("R1 reset rx", {24'd0, rx_byte}, 32'd0);

    ignored_code(3'd6);
    do_start();
    ignored_code(3'd7);
    do_write(8'hA5, 1'b1);
    do_ack_in(0, 8'h00);
    do_read(8'h96);
    do_ack_out();
    do_read(8'h01);
    do_ack_in(3, 8'h5A);
    do_start();
    do_write(8'h3C, 1'b0);
    do_ack_in(7, 8'hC3);
    do_ack_in(8, 8'h00);
    do_write(8'hFF, 1'b0);
    do_ack_in(0, 8'h00);
    do_ack_in(1, 8'h80);
    do_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule